// File: doc/BRIEF.md
# Register File Block Admission Unit

This unit decides, one request per cycle, whether a new thread block may become resident on a streaming multiprocessor. Each request carries the block's thread count and the number of registers each thread uses. The block is admitted only if three budgets all have room at once: a contiguous stretch of the register file, the warp slots, and the block slots. On admission the unit reserves the registers and returns the first register index of the range and the block slot number. When a resident block finishes, its slot number is presented on the release port and everything it held goes back to the pools.

The register file of 16,384 32-bit registers is managed as a bitmap of 256-register chunks. A block's demand is registers per thread times threads, rounded up to whole chunks. Placement is first-fit over that bitmap, so each block owns one contiguous range that no other resident block can reach. A warp is 32 threads, and a partly filled last warp still takes a full warp slot. A refused request is not dropped. The requester keeps it valid until a release makes room, using a valid/ready handshake.

Top module: `rfa_admit`

## Requirements
- R1: After reset, and after any later reset, the free-register count reads 16384, and the resident warp and block counts read 0. With no valid request, reqReady is low.
- R2: A block's register demand is reqThreads × reqRegsPerThread, rounded up to a multiple of 256. On acceptance the free-register count drops by exactly that amount. For example, 32 threads × 100 registers takes 13 chunks (3328 registers).
- R3: A block's warp count is reqThreads divided by 32, rounded up (33 threads take 2 warps). On acceptance the resident warp count rises by that amount.
- R4: While 8 blocks are resident, every request is refused.
- R5: A request is refused if the resident warps plus its warps would exceed 32. A request that brings the total to exactly 32 is accepted.
- R6: With 256-thread blocks, 20 registers per thread admits three blocks and refuses a fourth. At 22 registers per thread, 66 chunks would be needed for three blocks, so only two fit.
- R7: grantBase is 256 times the lowest chunk index that starts a run of free chunks long enough for the request.
- R8: A request is refused when no single free run is long enough, even if the total of free registers would cover it.
- R9: grantSlot is the lowest-numbered block slot that is not occupied.
- R10: A release returns the block's registers, warps and slot at the clock edge where it is presented. A held request that then fits is accepted in the next cycle.
- R11: A refused request (reqValid high, reqReady low) changes no state, and it stays refused for as long as nothing is released.
- R12: A new grant never covers a chunk that is held by a resident block.
- R13: A release and an acceptance in the same cycle both take effect. The admission decision is made against the state before the release.
- R14: A release naming an unoccupied slot changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Admission request present |
| reqThreads | input | 10 | Threads in the requesting block |
| reqRegsPerThread | input | 8 | Registers used by each thread |
| reqReady | output | 1 | Request accepted this cycle |
| grantBase | output | 14 | First register index of the reserved range (valid with reqReady) |
| grantSlot | output | 3 | Block slot given to the block (valid with reqReady) |
| relValid | input | 1 | A resident block has finished |
| relSlot | input | 3 | Slot of the finishing block |
| freeRegs | output | 15 | Registers not reserved by any block |
| residentWarps | output | 6 | Warp slots in use |
| residentBlocks | output | 4 | Block slots in use |

## Verification
The assertions assume three things about the inputs:
- The requester holds a refused request steady.
- A release names a slot whose block was actually admitted, except in the single deliberate case that tests R14.
- Requests have at least one thread.

The stimulus meets these assumptions because it is built as a scripted sequence. Every release in that sequence names a slot the script has already seen granted, and every request payload is non-zero. Within those limits, the assertions check four invariants:
- Grants never overlap held chunks.
- The free counter matches the bitmap.
- The block counter matches the occupied slots.
- The warp and block caps are never exceeded.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  // strobes issued by the control to the datapath for one cycle
  typedef struct packed {
    logic allocEn;
    logic freeEn;
  } rfaStrobe_t;
endpackage

// File: rtl/rfa_control.sv
module rfa_control
  import rfa_pkg::*;
#(
  parameter int THR_W = 10,
  parameter int RPT_W = 8,
  parameter int WARP_LANES = 32,
  parameter int CHUNK_REGS = 256,
  parameter int NEED_W = 11,
  parameter int WPB_W = 6
) (
  input  logic              reqValid,
  input  logic [THR_W-1:0]  reqThreads,
  input  logic [RPT_W-1:0]  reqRegsPerThread,
  input  logic              relValid,
  input  logic              fitFound,
  input  logic              warpOk,
  input  logic              slotAvail,
  input  logic              relHit,
  output logic [NEED_W-1:0] needChunks,
  output logic [WPB_W-1:0]  needWarps,
  output logic              reqReady,
  output rfaStrobe_t        strobe
);
  localparam int DEM_W    = THR_W + RPT_W;
  localparam int CHUNK_SH = $clog2(CHUNK_REGS);
  localparam int LANE_SH  = $clog2(WARP_LANES);

  logic [DEM_W-1:0] demand;
  logic [THR_W:0]   thrRound;

  // sizing: registers rounded up to chunks, threads rounded up to warps
  always_comb begin
    demand     = DEM_W'(reqThreads) * DEM_W'(reqRegsPerThread);
    needChunks = NEED_W'(demand >> CHUNK_SH) + NEED_W'(|demand[CHUNK_SH-1:0]);
    thrRound   = {1'b0, reqThreads} + (THR_W+1)'(WARP_LANES - 1);
    needWarps  = WPB_W'(thrRound >> LANE_SH);
  end

  // decision: all three budgets must have room at once
  always_comb begin
    reqReady       = reqValid && fitFound && warpOk && slotAvail;
    strobe.allocEn = reqReady;
    strobe.freeEn  = relValid && relHit;
  end
endmodule

// File: rtl/rfa_datapath.sv
module rfa_datapath
  import rfa_pkg::*;
#(
  parameter int CHUNKS = 64,
  parameter int MAX_BLOCKS = 8,
  parameter int MAX_WARPS = 32,
  parameter int NEED_W = 11,
  parameter int WPB_W = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rfaStrobe_t                    strobe,
  input  logic [NEED_W-1:0]             needChunks,
  input  logic [WPB_W-1:0]              needWarps,
  input  logic [$clog2(MAX_BLOCKS)-1:0] relSlot,
  output logic                          fitFound,
  output logic                          warpOk,
  output logic                          slotAvail,
  output logic                          relHit,
  output logic [$clog2(CHUNKS)-1:0]     fitIdx,
  output logic [$clog2(MAX_BLOCKS)-1:0] slotPick,
  output logic [$clog2(CHUNKS+1)-1:0]   freeChunks,
  output logic [$clog2(MAX_WARPS+1)-1:0] warpCnt,
  output logic [$clog2(MAX_BLOCKS+1)-1:0] blkCnt
);
  localparam int CIDX_W = $clog2(CHUNKS);
  localparam int CCNT_W = $clog2(CHUNKS + 1);
  localparam int SLOT_W = $clog2(MAX_BLOCKS);
  localparam int WCNT_W = $clog2(MAX_WARPS + 1);
  localparam int BCNT_W = $clog2(MAX_BLOCKS + 1);
  localparam int CMP_W  = (NEED_W > CCNT_W) ? NEED_W : CCNT_W;

  logic [CHUNKS-1:0]     usedMap;
  logic [MAX_BLOCKS-1:0] slotOcc;
  logic [CIDX_W-1:0]     slotBase  [MAX_BLOCKS];
  logic [CCNT_W-1:0]     slotLen   [MAX_BLOCKS];
  logic [WPB_W-1:0]      slotWarps [MAX_BLOCKS];

  logic [CCNT_W-1:0] runLen [CHUNKS];
  logic [CHUNKS-1:0] fitHit;
  logic [CHUNKS-1:0] allocMask;
  logic [CHUNKS-1:0] freeMask;

  // free run length starting at each chunk, built from the top down
  generate
    for (genvar c = 0; c < CHUNKS; c++) begin : g_run
      if (c == CHUNKS - 1) begin : g_top
        assign runLen[c] = usedMap[c] ? '0 : CCNT_W'(1);
      end else begin : g_mid
        assign runLen[c] = usedMap[c] ? '0 : runLen[c+1] + CCNT_W'(1);
      end
      assign fitHit[c] = CMP_W'(runLen[c]) >= CMP_W'(needChunks);
    end
  endgenerate

  // first fit: lowest start chunk with a long enough run
  always_comb begin
    fitIdx = '0;
    for (int c = CHUNKS - 1; c >= 0; c--) begin
      if (fitHit[c]) fitIdx = CIDX_W'(c);
    end
    fitFound = |fitHit;
  end

  // lowest free block slot
  always_comb begin
    slotPick = '0;
    for (int s = MAX_BLOCKS - 1; s >= 0; s--) begin
      if (!slotOcc[s]) slotPick = SLOT_W'(s);
    end
    slotAvail = ~&slotOcc;
    relHit    = slotOcc[relSlot];
    warpOk    = (int'(warpCnt) + int'(needWarps)) <= MAX_WARPS;
  end

  // chunk masks for the range being granted and the range being returned
  always_comb begin
    for (int c = 0; c < CHUNKS; c++) begin
      allocMask[c] = (c >= int'(fitIdx)) && (c < int'(fitIdx) + int'(needChunks));
      freeMask[c]  = (c >= int'(slotBase[relSlot])) &&
                     (c < int'(slotBase[relSlot]) + int'(slotLen[relSlot]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usedMap    <= '0;
      slotOcc    <= '0;
      freeChunks <= CCNT_W'(CHUNKS);
      warpCnt    <= '0;
      blkCnt     <= '0;
      for (int s = 0; s < MAX_BLOCKS; s++) begin
        slotBase[s]  <= '0;
        slotLen[s]   <= '0;
        slotWarps[s] <= '0;
      end
    end else begin
      usedMap <= (usedMap & ~(strobe.freeEn ? freeMask : '0)) |
                 (strobe.allocEn ? allocMask : '0);
      freeChunks <= freeChunks
                    - (strobe.allocEn ? CCNT_W'(needChunks) : '0)
                    + (strobe.freeEn ? slotLen[relSlot] : '0);
      warpCnt <= warpCnt
                 + (strobe.allocEn ? WCNT_W'(needWarps) : '0)
                 - (strobe.freeEn ? WCNT_W'(slotWarps[relSlot]) : '0);
      blkCnt <= blkCnt + BCNT_W'(strobe.allocEn) - BCNT_W'(strobe.freeEn);
      if (strobe.freeEn) slotOcc[relSlot] <= 1'b0;
      if (strobe.allocEn) begin
        slotOcc[slotPick]   <= 1'b1;
        slotBase[slotPick]  <= fitIdx;
        slotLen[slotPick]   <= CCNT_W'(needChunks);
        slotWarps[slotPick] <= needWarps;
      end
    end
  end

  // R12
  alloc_disjoint_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.allocEn |-> ((allocMask & usedMap) == '0));
  // R2
  free_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeChunks) == CHUNKS - $countones(usedMap));
  // R4
  block_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(blkCnt) <= MAX_BLOCKS) && (int'(blkCnt) == $countones(slotOcc)));
  // R5
  warp_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(warpCnt) <= MAX_WARPS);
  // R10
  release_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.freeEn && !strobe.allocEn) |=> (blkCnt == $past(blkCnt) - BCNT_W'(1)));
  // R11
  refused_still_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.allocEn && !strobe.freeEn) |=> ($stable(usedMap) && $stable(warpCnt)));
endmodule

// File: rtl/rfa_admit.sv
module rfa_admit
  import rfa_pkg::*;
#(
  parameter int REG_COUNT  = 16384,
  parameter int CHUNK_REGS = 256,
  parameter int MAX_BLOCKS = 8,
  parameter int MAX_WARPS  = 32,
  parameter int WARP_LANES = 32,
  parameter int THR_W      = 10,
  parameter int RPT_W      = 8,
  localparam int CHUNKS    = REG_COUNT / CHUNK_REGS,
  localparam int REG_W     = $clog2(REG_COUNT),
  localparam int FREE_W    = $clog2(REG_COUNT + 1),
  localparam int SLOT_W    = $clog2(MAX_BLOCKS),
  localparam int WCNT_W    = $clog2(MAX_WARPS + 1),
  localparam int BCNT_W    = $clog2(MAX_BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [THR_W-1:0]  reqThreads,
  input  logic [RPT_W-1:0]  reqRegsPerThread,
  output logic              reqReady,
  output logic [REG_W-1:0]  grantBase,
  output logic [SLOT_W-1:0] grantSlot,
  input  logic              relValid,
  input  logic [SLOT_W-1:0] relSlot,
  output logic [FREE_W-1:0] freeRegs,
  output logic [WCNT_W-1:0] residentWarps,
  output logic [BCNT_W-1:0] residentBlocks
);
  localparam int CHUNK_SH = $clog2(CHUNK_REGS);
  localparam int NEED_W   = THR_W + RPT_W - CHUNK_SH + 1;
  localparam int WPB_W    = THR_W - $clog2(WARP_LANES) + 1;
  localparam int CIDX_W   = $clog2(CHUNKS);
  localparam int CCNT_W   = $clog2(CHUNKS + 1);

  rfaStrobe_t        strobe;
  logic [NEED_W-1:0] needChunks;
  logic [WPB_W-1:0]  needWarps;
  logic              fitFound, warpOk, slotAvail, relHit;
  logic [CIDX_W-1:0] fitIdx;
  logic [CCNT_W-1:0] freeChunks;

  rfa_control #(
    .THR_W(THR_W), .RPT_W(RPT_W), .WARP_LANES(WARP_LANES),
    .CHUNK_REGS(CHUNK_REGS), .NEED_W(NEED_W), .WPB_W(WPB_W)
  ) ctrl_i (
    .reqValid(reqValid), .reqThreads(reqThreads),
    .reqRegsPerThread(reqRegsPerThread), .relValid(relValid),
    .fitFound(fitFound), .warpOk(warpOk), .slotAvail(slotAvail),
    .relHit(relHit), .needChunks(needChunks), .needWarps(needWarps),
    .reqReady(reqReady), .strobe(strobe)
  );

  rfa_datapath #(
    .CHUNKS(CHUNKS), .MAX_BLOCKS(MAX_BLOCKS), .MAX_WARPS(MAX_WARPS),
    .NEED_W(NEED_W), .WPB_W(WPB_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .needChunks(needChunks),
    .needWarps(needWarps), .relSlot(relSlot), .fitFound(fitFound),
    .warpOk(warpOk), .slotAvail(slotAvail), .relHit(relHit),
    .fitIdx(fitIdx), .slotPick(grantSlot), .freeChunks(freeChunks),
    .warpCnt(residentWarps), .blkCnt(residentBlocks)
  );

  assign grantBase = REG_W'(fitIdx) << CHUNK_SH;
  assign freeRegs  = FREE_W'(freeChunks) << CHUNK_SH;
endmodule

// File: tb/rfa_admit_tb.sv
module rfa_admit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [9:0]  reqThreads = '0;
  logic [7:0]  reqRegsPerThread = '0;
  logic        reqReady;
  logic [13:0] grantBase;
  logic [2:0]  grantSlot;
  logic        relValid = 1'b0;
  logic [2:0]  relSlot = '0;
  logic [14:0] freeRegs;
  logic [5:0]  residentWarps;
  logic [3:0]  residentBlocks;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  rfa_admit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqThreads(reqThreads),
    .reqRegsPerThread(reqRegsPerThread), .reqReady(reqReady),
    .grantBase(grantBase), .grantSlot(grantSlot), .relValid(relValid),
    .relSlot(relSlot), .freeRegs(freeRegs), .residentWarps(residentWarps),
    .residentBlocks(residentBlocks)
  );

  typedef struct packed {
    logic        isRel;
    logic [9:0]  arg;      // threads, or slot for a release
    logic [7:0]  rpt;
    logic        expRdy;
    logic [13:0] expBase;
    logic [2:0]  expSlot;
    logic [14:0] expFree;
    logic [5:0]  expWarps;
    logic [3:0]  expBlocks;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 10'd256, 8'd20,  1'b1, 14'd0,     3'd0, 15'd11264, 6'd8,  4'd1},
    '{1'b0, 10'd256, 8'd20,  1'b1, 14'd5120,  3'd1, 15'd6144,  6'd16, 4'd2},
    '{1'b0, 10'd256, 8'd20,  1'b1, 14'd10240, 3'd2, 15'd1024,  6'd24, 4'd3},
    '{1'b0, 10'd256, 8'd20,  1'b0, 14'd0,     3'd0, 15'd1024,  6'd24, 4'd3},
    '{1'b1, 10'd1,   8'd0,   1'b0, 14'd0,     3'd0, 15'd6144,  6'd16, 4'd2},
    '{1'b0, 10'd64,  8'd32,  1'b1, 14'd5120,  3'd1, 15'd4096,  6'd18, 4'd3},
    '{1'b0, 10'd64,  8'd64,  1'b0, 14'd0,     3'd0, 15'd4096,  6'd18, 4'd3},
    '{1'b0, 10'd32,  8'd100, 1'b0, 14'd0,     3'd0, 15'd4096,  6'd18, 4'd3},
    '{1'b0, 10'd32,  8'd96,  1'b1, 14'd7168,  3'd3, 15'd1024,  6'd19, 4'd4},
    '{1'b0, 10'd33,  8'd1,   1'b1, 14'd15360, 3'd4, 15'd768,   6'd21, 4'd5},
    '{1'b0, 10'd1,   8'd1,   1'b1, 14'd15616, 3'd5, 15'd512,   6'd22, 4'd6},
    '{1'b0, 10'd1,   8'd1,   1'b1, 14'd15872, 3'd6, 15'd256,   6'd23, 4'd7},
    '{1'b0, 10'd1,   8'd1,   1'b1, 14'd16128, 3'd7, 15'd0,     6'd24, 4'd8},
    '{1'b1, 10'd0,   8'd0,   1'b0, 14'd0,     3'd0, 15'd5120,  6'd16, 4'd7},
    '{1'b0, 10'd1,   8'd1,   1'b1, 14'd0,     3'd0, 15'd4864,  6'd17, 4'd8},
    '{1'b0, 10'd1,   8'd1,   1'b0, 14'd0,     3'd0, 15'd4864,  6'd17, 4'd8},
    '{1'b1, 10'd2,   8'd0,   1'b0, 14'd0,     3'd0, 15'd9984,  6'd9,  4'd7},
    '{1'b0, 10'd512, 8'd1,   1'b1, 14'd256,   3'd2, 15'd9472,  6'd25, 4'd8},
    '{1'b1, 10'd7,   8'd0,   1'b0, 14'd0,     3'd0, 15'd9728,  6'd24, 4'd7},
    '{1'b0, 10'd320, 8'd1,   1'b0, 14'd0,     3'd0, 15'd9728,  6'd24, 4'd7},
    '{1'b0, 10'd256, 8'd1,   1'b1, 14'd768,   3'd7, 15'd9472,  6'd32, 4'd8},
    '{1'b1, 10'd4,   8'd0,   1'b0, 14'd0,     3'd0, 15'd9728,  6'd30, 4'd7},
    '{1'b0, 10'd65,  8'd1,   1'b0, 14'd0,     3'd0, 15'd9728,  6'd30, 4'd7},
    '{1'b0, 10'd64,  8'd1,   1'b1, 14'd1024,  3'd4, 15'd9472,  6'd32, 4'd8}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pools(input string tag, input int f, input int w, input int b);
    chk({tag, " freeRegs"}, int'(freeRegs), f);
    chk({tag, " residentWarps"}, int'(residentWarps), w);
    chk({tag, " residentBlocks"}, int'(residentBlocks), b);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0;
    relValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    pools("R1 reset", 16384, 0, 0);
    chk("R1 ready idle", int'(reqReady), 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (TBL[i].isRel) begin
        relValid = 1'b1;
        relSlot = TBL[i].arg[2:0];
      end else begin
        reqValid = 1'b1;
        reqThreads = TBL[i].arg;
        reqRegsPerThread = TBL[i].rpt;
        #1;
        chk($sformatf("R4/R5/R6/R8 row %0d ready", i), int'(reqReady), int'(TBL[i].expRdy));
        if (TBL[i].expRdy) begin
          chk($sformatf("R7 row %0d grantBase", i), int'(grantBase), int'(TBL[i].expBase));
          chk($sformatf("R9 row %0d grantSlot", i), int'(grantSlot), int'(TBL[i].expSlot));
        end
      end
      @(posedge clk);
      #1;
      reqValid = 1'b0;
      relValid = 1'b0;
      pools($sformatf("R2/R3/R10 row %0d", i), int'(TBL[i].expFree),
            int'(TBL[i].expWarps), int'(TBL[i].expBlocks));
    end

    // R1 reset in mid-run returns everything
    doReset();
    pools("R1 rerun reset", 16384, 0, 0);

    // R13 release and grant in the same cycle
    @(negedge clk);
    reqValid = 1'b1; reqThreads = 10'd256; reqRegsPerThread = 8'd20;
    @(posedge clk); #1;
    @(negedge clk);
    relValid = 1'b1; relSlot = 3'd0;
    #1;
    chk("R13 ready", int'(reqReady), 1);
    chk("R13 base", int'(grantBase), 5120);
    chk("R13 slot", int'(grantSlot), 1);
    @(posedge clk); #1;
    reqValid = 1'b0; relValid = 1'b0;
    pools("R13", 11264, 8, 1);

    // R14 release of an unoccupied slot
    @(negedge clk);
    relValid = 1'b1; relSlot = 3'd5;
    @(posedge clk); #1;
    relValid = 1'b0;
    pools("R14", 11264, 8, 1);

    // R11 and R10: held request waits for a release
    doReset();
    @(negedge clk);
    reqValid = 1'b1; reqThreads = 10'd256; reqRegsPerThread = 8'd64;
    #1;
    chk("R11 fill ready", int'(reqReady), 1);
    @(posedge clk); #1;
    pools("R11 full", 0, 8, 1);
    reqThreads = 10'd32; reqRegsPerThread = 8'd1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      chk("R11 held refused", int'(reqReady), 0);
      @(posedge clk); #1;
      pools("R11 unchanged", 0, 8, 1);
    end
    @(negedge clk);
    relValid = 1'b1; relSlot = 3'd0;
    #1;
    chk("R10 pre-release ready", int'(reqReady), 0);
    @(posedge clk); #1;
    relValid = 1'b0;
    pools("R10 released", 16384, 0, 0);
    @(negedge clk); #1;
    chk("R10 admit ready", int'(reqReady), 1);
    chk("R10 admit base", int'(grantBase), 0);
    chk("R10 admit slot", int'(grantSlot), 0);
    @(posedge clk); #1;
    reqValid = 1'b0;
    pools("R10 admitted", 16128, 1, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule